// File: doc/BRIEF.md
# I2C Master Command and Receive FIFO Front End

This block sits between a processor's register accesses and the byte engine of an I2C master. The processor queues work through a single data/command register. A write with bit 8 clear queues a byte to be transmitted. A write with bit 8 set queues a read request, which carries no payload. Reading the same register pops the oldest byte that the engine has received. The engine pops commands from the transmit queue and pushes received bytes into the receive queue, each through a one-cycle strobe.

Software paces a transfer with two level-driven requests. The transmit request is active while the transmit fill is at or below a programmable threshold. The receive request is active while the receive fill is above a separate threshold. Fill levels and a read-only word that describes both depths can be read back. Sticky flags record a write to a full transmit queue, a push into a full receive queue and a pop from an empty receive queue. A transfer abort empties both queues at once.

Top module: `i2cf_front`

## Requirements
- R1: A write to address 0 with bit 8 clear appends {0, bits 7:0} to the transmit queue. The engine sees the entries in write order on engCmdData while engCmdValid is high, and each engCmdPop removes the head.
- R2: A write to address 0 with bit 8 set appends a read request, and the engine sees it as 9'h100 whatever bits 7:0 held.
- R3: A read of address 0 returns the oldest received byte in bits 7:0 in the same cycle and removes it, so bytes leave in the order the engine pushed them.
- R4: Address 3 returns the transmit fill level and address 4 returns the receive fill level. Neither exceeds its depth.
- R5: txEmptyReq is high exactly while the transmit fill level is at or below the transmit threshold, which is written at address 1.
- R6: rxFullReq is high exactly while the receive fill level is above the receive threshold, which is written at address 2. With a threshold of 0, one stored byte raises it.
- R7: A threshold write stores min(value in bits 7:0, depth-1), and the stored value reads back from the same address.
- R8: While xferAbort is high, both queues are emptied at the clock edge. Writes, pops and pushes in that cycle add or remove nothing else.
- R9: Address 5 reads as (TX_DEPTH-1) in bits 23:16 and (RX_DEPTH-1) in bits 15:8, with all other bits zero.
- R10: A write to address 0 while the transmit queue is full is dropped and sets txOverFlag, even if the engine pops in the same cycle.
- R11: A read of address 0 while the receive queue is empty returns zero, leaves the level unchanged and sets rxUnderFlag.
- R12: An engine push while the receive queue is full is dropped and sets rxOverFlag.
- R13: The flags are sticky and read at address 6 as {txOver, rxOver, rxUnder} in bits 2:0. Writing 1 to one of those bits at address 6 clears that flag. If the flag is set again in the same cycle, the set wins.
- R14: After reset both levels are 0, both thresholds are 0, all flags are 0, txEmptyReq is 1 and rxFullReq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 9 | Register write data |
| regRdData | output | 32 | Register read data, combinational |
| engCmdValid | output | 1 | Transmit queue holds an entry |
| engCmdData | output | 9 | Head of the transmit queue; bit 8 marks a read request |
| engCmdPop | input | 1 | Engine takes the head command |
| engRxPush | input | 1 | Engine delivers a received byte |
| engRxData | input | 8 | Received byte |
| xferAbort | input | 1 | Transfer abort; flushes both queues |
| txEmptyReq | output | 1 | Transmit level at or below its threshold |
| rxFullReq | output | 1 | Receive level above its threshold |
| txOverFlag | output | 1 | Sticky transmit overflow |
| rxOverFlag | output | 1 | Sticky receive overflow |
| rxUnderFlag | output | 1 | Sticky receive underflow |

## Verification
Directed sequences fill each queue to the brim and one past it, drain each one to empty and one past it, and fire an abort while both queues are full and every strobe is active. These cases separate a correct full or empty guard from an off-by-one guard, and show whether the abort takes priority. Threshold writes above depth-1 check saturation, and a receive threshold of 0 checks the single-byte trigger. A long seeded random mix then interleaves processor writes, processor pops, engine pops and pushes, flag clears and rare aborts. A queue model in the bench predicts every read, every engine head and both requests, so ordering faults and same-cycle push/pop interactions show up as value mismatches.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    ADDR_DATA  = 3'd0,
    ADDR_TXTHR = 3'd1,
    ADDR_RXTHR = 3'd2,
    ADDR_TXLVL = 3'd3,
    ADDR_RXLVL = 3'd4,
    ADDR_PARAM = 3'd5,
    ADDR_FLAGS = 3'd6
  } regAddr_e;

  // strobes from control to datapath, all qualified (never push full / pop empty)
  typedef struct packed {
    logic txWrite;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } fifoStrobes_t;

endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [WIDTH-1:0]           wrData,
  output logic [WIDTH-1:0]           headData,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [LW-1:0]    count;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) store[wrPtr] <= wrData;
  end

  assign headData = store[rdPtr];
  assign level    = count;

endmodule

// File: rtl/i2cf_datapath.sv
module i2cf_datapath
  import i2cf_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fifoStrobes_t                  strobes,
  input  logic [8:0]                    cmdWord,
  input  logic [7:0]                    rxByte,
  output logic [8:0]                    txHead,
  output logic [7:0]                    rxHead,
  output logic [$clog2(TX_DEPTH+1)-1:0] txLevel,
  output logic [$clog2(RX_DEPTH+1)-1:0] rxLevel
);
  logic [8:0] txEntry;

  // a read request carries no payload: drop the low byte
  assign txEntry = cmdWord[8] ? 9'h100 : {1'b0, cmdWord[7:0]};

  i2cf_fifo #(.WIDTH(9), .DEPTH(TX_DEPTH)) txQueue (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .push     (strobes.txWrite),
    .pop      (strobes.txPop),
    .wrData   (txEntry),
    .headData (txHead),
    .level    (txLevel)
  );

  i2cf_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) rxQueue (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .push     (strobes.rxPush),
    .pop      (strobes.rxPop),
    .wrData   (rxByte),
    .headData (rxHead),
    .level    (rxLevel)
  );

endmodule

// File: rtl/i2cf_ctrl.sv
module i2cf_ctrl
  import i2cf_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic                          regRdEn,
  input  logic [REG_AW-1:0]             regAddr,
  input  logic [7:0]                    wrLow,
  output logic [31:0]                   regRdData,
  input  logic                          engCmdPop,
  input  logic                          engRxPush,
  input  logic                          xferAbort,
  input  logic [$clog2(TX_DEPTH+1)-1:0] txLevel,
  input  logic [$clog2(RX_DEPTH+1)-1:0] rxLevel,
  input  logic [7:0]                    rxHead,
  output fifoStrobes_t                  strobes,
  output logic                          txEmptyReq,
  output logic                          rxFullReq,
  output logic                          txOverFlag,
  output logic                          rxOverFlag,
  output logic                          rxUnderFlag
);
  localparam int TLW = $clog2(TX_DEPTH+1);
  localparam int RLW = $clog2(RX_DEPTH+1);
  localparam logic [7:0] TX_MAX = 8'(TX_DEPTH-1);
  localparam logic [7:0] RX_MAX = 8'(RX_DEPTH-1);
  localparam logic [31:0] PARAM_WORD = {8'h00, TX_MAX, RX_MAX, 8'h00};

  logic [7:0] txThr, rxThr;
  logic dataWr, dataRd, flagWr, txFull, rxFull, rxEmpty;
  logic setTxOver, setRxOver, setRxUnder;

  assign dataWr  = regWrEn && (regAddr == ADDR_DATA);
  assign dataRd  = regRdEn && (regAddr == ADDR_DATA);
  assign flagWr  = regWrEn && (regAddr == ADDR_FLAGS);
  assign txFull  = (txLevel == TLW'(TX_DEPTH));
  assign rxFull  = (rxLevel == RLW'(RX_DEPTH));
  assign rxEmpty = (rxLevel == '0);

  // queue strobes: abort overrides every other queue operation
  always_comb begin
    strobes.flush   = xferAbort;
    strobes.txWrite = dataWr && !txFull && !xferAbort;
    strobes.txPop   = engCmdPop && (txLevel != '0) && !xferAbort;
    strobes.rxPush  = engRxPush && !rxFull && !xferAbort;
    strobes.rxPop   = dataRd && !rxEmpty && !xferAbort;
  end

  assign setTxOver  = dataWr && txFull;
  assign setRxOver  = engRxPush && rxFull;
  assign setRxUnder = dataRd && rxEmpty;

  function automatic logic [7:0] clampThr(input logic [7:0] v, input logic [7:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThr <= '0;
      rxThr <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_TXTHR) txThr <= clampThr(wrLow, TX_MAX);
      if (regAddr == ADDR_RXTHR) rxThr <= clampThr(wrLow, RX_MAX);
    end
  end

  // sticky flags, set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverFlag  <= 1'b0;
      rxOverFlag  <= 1'b0;
      rxUnderFlag <= 1'b0;
    end else begin
      txOverFlag  <= setTxOver  | (txOverFlag  & ~(flagWr & wrLow[2]));
      rxOverFlag  <= setRxOver  | (rxOverFlag  & ~(flagWr & wrLow[1]));
      rxUnderFlag <= setRxUnder | (rxUnderFlag & ~(flagWr & wrLow[0]));
    end
  end

  assign txEmptyReq = ({{(16-TLW){1'b0}}, txLevel} <= {8'h00, txThr});
  assign rxFullReq  = ({{(16-RLW){1'b0}}, rxLevel} >  {8'h00, rxThr});

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        ADDR_DATA:  regRdData = rxEmpty ? 32'h0 : {24'h0, rxHead};
        ADDR_TXTHR: regRdData = {24'h0, txThr};
        ADDR_RXTHR: regRdData = {24'h0, rxThr};
        ADDR_TXLVL: regRdData = 32'(txLevel);
        ADDR_RXLVL: regRdData = 32'(rxLevel);
        ADDR_PARAM: regRdData = PARAM_WORD;
        ADDR_FLAGS: regRdData = {29'h0, txOverFlag, rxOverFlag, rxUnderFlag};
        default:    regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/i2cf_front.sv
module i2cf_front
  import i2cf_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [8:0]  regWrData,
  output logic [31:0] regRdData,
  output logic        engCmdValid,
  output logic [8:0]  engCmdData,
  input  logic        engCmdPop,
  input  logic        engRxPush,
  input  logic [7:0]  engRxData,
  input  logic        xferAbort,
  output logic        txEmptyReq,
  output logic        rxFullReq,
  output logic        txOverFlag,
  output logic        rxOverFlag,
  output logic        rxUnderFlag
);
  localparam int TLW = $clog2(TX_DEPTH+1);
  localparam int RLW = $clog2(RX_DEPTH+1);

  fifoStrobes_t   strobes;
  logic [TLW-1:0] txLevel;
  logic [RLW-1:0] rxLevel;
  logic [7:0]     rxHead;

  i2cf_ctrl #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regAddr     (regAddr),
    .wrLow       (regWrData[7:0]),
    .regRdData   (regRdData),
    .engCmdPop   (engCmdPop),
    .engRxPush   (engRxPush),
    .xferAbort   (xferAbort),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .rxHead      (rxHead),
    .strobes     (strobes),
    .txEmptyReq  (txEmptyReq),
    .rxFullReq   (rxFullReq),
    .txOverFlag  (txOverFlag),
    .rxOverFlag  (rxOverFlag),
    .rxUnderFlag (rxUnderFlag)
  );

  i2cf_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cmdWord (regWrData),
    .rxByte  (engRxData),
    .txHead  (engCmdData),
    .rxHead  (rxHead),
    .txLevel (txLevel),
    .rxLevel (rxLevel)
  );

  assign engCmdValid = (txLevel != '0);

endmodule

// File: rtl/i2cf_front_chk.sv
module i2cf_front_chk #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [2:0]  regAddr,
  input logic [8:0]  regWrData,
  input logic [31:0] regRdData,
  input logic        engCmdPop,
  input logic        engRxPush,
  input logic        xferAbort,
  input logic        txOverFlag,
  input logic        rxOverFlag,
  input logic        rxUnderFlag,
  input logic [$clog2(TX_DEPTH+1)-1:0] txLevel,
  input logic [$clog2(RX_DEPTH+1)-1:0] rxLevel
);
  localparam int TLW = $clog2(TX_DEPTH+1);
  localparam int RLW = $clog2(RX_DEPTH+1);
  localparam logic [TLW-1:0] TFULL = TLW'(TX_DEPTH);
  localparam logic [RLW-1:0] RFULL = RLW'(RX_DEPTH);

  logic dataWr, dataRd;
  assign dataWr = regWrEn && (regAddr == 3'd0);
  assign dataRd = regRdEn && (regAddr == 3'd0);

  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= TFULL) && (rxLevel <= RFULL));

  a_r1_write_grows: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && txLevel != TFULL && !engCmdPop && !xferAbort) |=> (txLevel == $past(txLevel) + 1'b1));

  a_r8_abort_flush: assert property (@(posedge clk) disable iff (!rstN)
    xferAbort |=> (txLevel == '0) && (rxLevel == '0));

  a_r10_full_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && txLevel == TFULL && !engCmdPop && !xferAbort) |=> (txLevel == TFULL) && txOverFlag);

  a_r11_empty_pop_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && rxLevel == '0) |-> (regRdData == 32'h0));

  a_r11_empty_pop_flag: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && rxLevel == '0) |=> rxUnderFlag);

  a_r12_rx_over: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxLevel == RFULL) |=> rxOverFlag);

  a_r13_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txOverFlag && !(regWrEn && regAddr == 3'd6 && regWrData[2])) |=> txOverFlag);

endmodule

bind i2cf_front i2cf_front_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) chkInst (.*);

// File: tb/i2cf_front_test.sv
module i2cf_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 8;
  localparam int RD = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0, engCmdPop = 0, engRxPush = 0, xferAbort = 0;
  logic [2:0]  regAddr = '0;
  logic [8:0]  regWrData = '0;
  logic [7:0]  engRxData = '0;
  logic [31:0] regRdData;
  logic        engCmdValid, txEmptyReq, rxFullReq, txOverFlag, rxOverFlag, rxUnderFlag;
  logic [8:0]  engCmdData;

  i2cf_front #(.TX_DEPTH(TD), .RX_DEPTH(RD)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [8:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [7:0] mTxThr = 0, mRxThr = 0;
  logic mTxOver = 0, mRxOver = 0, mRxUnder = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] readModel(input logic [2:0] a);
    case (a)
      3'd0: return (rxQ.size() == 0) ? 32'h0 : {24'h0, rxQ[0]};
      3'd1: return {24'h0, mTxThr};
      3'd2: return {24'h0, mRxThr};
      3'd3: return 32'(txQ.size());
      3'd4: return 32'(rxQ.size());
      3'd5: return {8'h00, 8'(TD-1), 8'(RD-1), 8'h00};
      3'd6: return {29'h0, mTxOver, mRxOver, mRxUnder};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] sat(input logic [7:0] v, input int lim);
    return (int'(v) > lim) ? 8'(lim) : v;
  endfunction

  // one clock: drive at negedge, check combinational outputs, predict, check after edge
  task automatic step(input bit wr, input bit rd, input logic [2:0] a, input logic [8:0] wd,
                      input bit ePop, input bit ePush, input logic [7:0] eData,
                      input bit ab, input string tag);
    int preTx, preRx;
    bit clr0, clr1, clr2;
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd;
    engCmdPop = ePop; engRxPush = ePush; engRxData = eData; xferAbort = ab;
    #1;
    if (rd) chk(tag, regRdData, readModel(a));
    chk({tag, " R1 valid"}, 32'(engCmdValid), 32'(txQ.size() > 0));
    if (txQ.size() > 0) chk({tag, " R1 head"}, 32'(engCmdData), 32'(txQ[0]));
    preTx = txQ.size(); preRx = rxQ.size();
    clr0 = wr && a == 3'd6 && wd[0];
    clr1 = wr && a == 3'd6 && wd[1];
    clr2 = wr && a == 3'd6 && wd[2];
    mTxOver  = (wr && a == 3'd0 && preTx == TD) | (mTxOver & ~clr2);
    mRxOver  = (ePush && preRx == RD) | (mRxOver & ~clr1);
    mRxUnder = (rd && a == 3'd0 && preRx == 0) | (mRxUnder & ~clr0);
    if (wr && a == 3'd1) mTxThr = sat(wd[7:0], TD-1);
    if (wr && a == 3'd2) mRxThr = sat(wd[7:0], RD-1);
    if (ab) begin
      txQ.delete(); rxQ.delete();
    end else begin
      if (ePop && preTx > 0) void'(txQ.pop_front());
      if (wr && a == 3'd0 && preTx < TD) txQ.push_back(wd[8] ? 9'h100 : {1'b0, wd[7:0]});
      if (rd && a == 3'd0 && preRx > 0) void'(rxQ.pop_front());
      if (ePush && preRx < RD) rxQ.push_back(eData);
    end
    @(negedge clk);
    regWrEn = 0; regRdEn = 0; engCmdPop = 0; engRxPush = 0; xferAbort = 0;
    #1;
    chk("R5 txEmptyReq", 32'(txEmptyReq), 32'(txQ.size() <= int'(mTxThr)));
    chk("R6 rxFullReq", 32'(rxFullReq), 32'(rxQ.size() > int'(mRxThr)));
    chk("R13 flags", {29'h0, txOverFlag, rxOverFlag, rxUnderFlag}, {29'h0, mTxOver, mRxOver, mRxUnder});
  endtask

  task automatic rdReg(input logic [2:0] a, input string tag);
    step(0, 1, a, '0, 0, 0, '0, 0, tag);
  endtask
  task automatic wrReg(input logic [2:0] a, input logic [8:0] d, input string tag);
    step(1, 0, a, d, 0, 0, '0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk("R14 txEmptyReq", 32'(txEmptyReq), 32'd1);
    chk("R14 rxFullReq", 32'(rxFullReq), 32'd0);
    rdReg(3'd3, "R14 R4 txLevel");
    rdReg(3'd4, "R14 R4 rxLevel");
    rdReg(3'd1, "R14 txThr");
    rdReg(3'd2, "R14 rxThr");
    rdReg(3'd6, "R14 flags");
    rdReg(3'd5, "R9 param");
    chk("R9 literal", readModel(3'd5), 32'h0007_0700);
    // R1 / R2 ordering and read request encoding
    wrReg(3'd0, 9'h03C, "R1");
    wrReg(3'd0, 9'h1A5, "R2");
    wrReg(3'd0, 9'h0F0, "R1");
    chk("R2 encode", 32'(txQ[1]), 32'h100);
    rdReg(3'd3, "R4 txLevel");
    repeat (3) step(0, 0, 3'd0, '0, 1, 0, '0, 0, "R1 drain");
    // R7 saturation
    wrReg(3'd1, 9'h0C8, "R7");
    rdReg(3'd1, "R7 txThr sat");
    chk("R7 value", readModel(3'd1), 32'd7);
    wrReg(3'd1, 9'h002, "R7");
    rdReg(3'd1, "R7 txThr");
    // R10 fill TX, then write full with simultaneous engine pop
    for (int i = 0; i < TD; i++) wrReg(3'd0, 9'(i + 16), "R10 fill");
    wrReg(3'd0, 9'h055, "R10 overflow");
    step(1, 0, 3'd0, 9'h066, 1, 0, '0, 0, "R10 full with pop");
    rdReg(3'd3, "R10 level");
    // R12 fill RX and overflow
    for (int i = 0; i < RD + 1; i++) step(0, 0, 3'd0, '0, 0, 1, 8'(8'hA0 + i), 0, "R12 push");
    rdReg(3'd4, "R12 level");
    // R3 order, R11 underflow
    for (int i = 0; i < RD; i++) rdReg(3'd0, "R3 pop");
    rdReg(3'd0, "R11 empty pop");
    rdReg(3'd4, "R11 level");
    // R13 clear, with set winning over clear
    rdReg(3'd6, "R13 flags");
    step(1, 0, 3'd6, 9'h007, 0, 0, '0, 0, "R13 clear");
    rdReg(3'd6, "R13 cleared");
    step(0, 1, 3'd0, '0, 0, 0, '0, 0, "R11 set");
    step(1, 0, 3'd6, 9'h001, 0, 0, '0, 0, "R13 clear");
    rdReg(3'd6, "R13 after clear");
    // R6 threshold 0: one byte raises the request
    wrReg(3'd2, 9'h000, "R6");
    step(0, 0, 3'd0, '0, 0, 1, 8'h5A, 0, "R6 one byte");
    chk("R6 single byte", 32'(rxFullReq), 32'd1);
    // R8 abort with full queues and all strobes active
    for (int i = 0; i < TD; i++) wrReg(3'd0, 9'(i), "R8 fill");
    for (int i = 0; i < RD; i++) step(0, 0, 3'd0, '0, 0, 1, 8'(i), 0, "R8 fill");
    step(1, 0, 3'd0, 9'h011, 1, 1, 8'h22, 1, "R8 abort");
    rdReg(3'd3, "R8 txLevel");
    rdReg(3'd4, "R8 rxLevel");
    chk("R8 valid", 32'(engCmdValid), 32'd0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      bit wr, rd;
      logic [2:0] a;
      logic [8:0] d;
      op = int'($urandom_range(0, 99));
      wr = 0; rd = 0; a = 3'd0; d = 9'($urandom);
      if (op < 30) wr = 1;
      else if (op < 55) rd = 1;
      else if (op < 62) begin wr = 1; a = 3'($urandom_range(1, 2)); d = 9'($urandom_range(0, 15)); end
      else if (op < 80) begin rd = 1; a = 3'($urandom_range(1, 7)); end
      else if (op < 84) begin wr = 1; a = 3'd6; end
      step(wr, rd, a, d, $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 40,
           8'($urandom), $urandom_range(0, 63) == 0, "R3 R4 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule